// File: doc/BRIEF.md
# Adapter Reset Bring-Up Sequencer

This block steps an adapter out of reset and into working order. It drives three active-low reset controls: one for the adapter core, one for its host-interface section and one for its data FIFO. After the resets it sets an interrupt-enable pair and then loads an 8-bit FIFO threshold. Three single-cycle requests start its sequences:

- An **open** request runs the full bring-up.
- A **close** request puts every section back into reset.
- An **enable-only** request takes the core out of reset and waits. Firmware uses it before reading configuration data.

Delays are measured in time units. One time unit is `TICK_DIV` pulses of the `us_tick` input. A hold lasts `HOLD_UNITS` time units, so a bench can shrink both counts. `busy` is high while a sequence runs. `done` pulses for one cycle when a sequence finishes.

Top module: `adapter_bringup_seq`

## Requirements
- R1: During and right after reset, all three reset controls, both interrupt enables, the threshold, `busy` and `done` are 0.
- R2: An enable-only request sets `core_nres` and `busy` at the next edge and leaves `host_nres` and `fifo_nres` unchanged. `done` rises and `busy` falls exactly `HOLD_UNITS*TICK_DIV` clock cycles later when `us_tick` is held high.
- R3: An open request first sets `core_nres` (cycle 1). At the following edge it clears all three reset controls together (cycle 2).
- R4: All three resets then stay low for `HOLD_UNITS` time units; with `us_tick` high every cycle this is `HOLD_UNITS*TICK_DIV` cycles.
- R5: The resets are released on three consecutive edges: core, then host interface, then FIFO. No two of them rise in the same cycle.
- R6: One cycle after the FIFO release, `irq_sys_en` and `irq_err_en` are both set.
- R7: One cycle after that, `fifo_thresh` takes the value `THRESH_VAL` (default 30), `done` pulses and `busy` falls.
- R8: A close request clears all three reset controls at the next edge and pulses `done` at that same edge. The interrupt enables and the threshold keep their values, and `busy` stays low.
- R9: Any request that arrives while `busy` is high is ignored; the running sequence keeps its timing and values.
- R10: When requests arrive together in idle, close wins over open, and open wins over enable-only.
- R11: `busy` stays high from the accepting edge until the edge that raises `done`. `done` is high for one cycle and never together with `busy`.
- R12: Hold time advances only on cycles with `us_tick` high. While the tick is held low, a wait does not end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | Timing tick; `TICK_DIV` ticks make one time unit |
| open_req | input | 1 | Start full bring-up |
| close_req | input | 1 | Return all sections to reset |
| enable_req | input | 1 | Release the core only, then wait |
| core_nres | output | 1 | Core not-reset |
| host_nres | output | 1 | Host-interface not-reset |
| fifo_nres | output | 1 | FIFO not-reset |
| irq_sys_en | output | 1 | System interrupt enable |
| irq_err_en | output | 1 | Bus-error interrupt enable |
| fifo_thresh | output | 8 | FIFO threshold value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the request inputs are synchronous to `clk`. They also assume that the outputs change only through this block, so every rising reset edge comes from the release steps or from an enable-only request. An enable-only request is only issued after a close or after a completed open, when the host and FIFO resets are either both low or both high. The stimulus follows this rule: it drives requests and the tick only on falling edges, one scenario at a time. It injects extra requests only inside a running sequence, to exercise the ignore rule.

// File: rtl/abs_pkg.sv
package abs_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_EN_WAIT,
    S_OP_CLR,
    S_OP_HOLD,
    S_REL_HOST,
    S_REL_FIFO,
    S_IRQ_WR,
    S_THR_WR
  } seq_state_t;

  typedef enum logic [1:0] {
    RQ_NONE,
    RQ_CLOSE,
    RQ_OPEN,
    RQ_EN
  } req_kind_t;

  // Fixed priority: close over open over enable-only.
  function automatic req_kind_t pick_req(input logic open_r, input logic close_r,
                                         input logic en_r);
    if (close_r)     return RQ_CLOSE;
    else if (open_r) return RQ_OPEN;
    else if (en_r)   return RQ_EN;
    else             return RQ_NONE;
  endfunction

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic unit_pulse
);
  import abs_pkg::*;
  localparam int W = cnt_width(TICK_DIV);
  localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

  logic [W-1:0] cnt_q;

  assign unit_pulse = tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (tick)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int HOLD_UNITS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic unit_pulse,
  output logic expire
);
  import abs_pkg::*;
  localparam int W = cnt_width(HOLD_UNITS);
  localparam logic [W-1:0] LAST = W'(HOLD_UNITS - 1);

  logic [W-1:0] cnt_q;

  assign expire = run && unit_pulse && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr)               cnt_q <= '0;
    else if (run && unit_pulse && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm #(
  parameter int THR_W      = 8,
  parameter int THRESH_VAL = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_req,
  input  logic             close_req,
  input  logic             enable_req,
  input  logic             expire,
  output logic             tmr_run,
  output logic             close_acc,
  output logic             core_nres,
  output logic             host_nres,
  output logic             fifo_nres,
  output logic             irq_sys_en,
  output logic             irq_err_en,
  output logic [THR_W-1:0] fifo_thresh,
  output logic             busy,
  output logic             done
);
  import abs_pkg::*;

  seq_state_t state_q;
  req_kind_t  req_sel;

  assign req_sel   = pick_req(open_req, close_req, enable_req);
  assign tmr_run   = (state_q == S_EN_WAIT) || (state_q == S_OP_HOLD);
  assign close_acc = (state_q == S_IDLE) && (req_sel == RQ_CLOSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      core_nres   <= 1'b0;
      host_nres   <= 1'b0;
      fifo_nres   <= 1'b0;
      irq_sys_en  <= 1'b0;
      irq_err_en  <= 1'b0;
      fifo_thresh <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          unique case (req_sel)
            RQ_CLOSE: begin
              core_nres <= 1'b0;
              host_nres <= 1'b0;
              fifo_nres <= 1'b0;
              done      <= 1'b1;
            end
            RQ_OPEN: begin
              core_nres <= 1'b1;
              busy      <= 1'b1;
              state_q   <= S_OP_CLR;
            end
            RQ_EN: begin
              core_nres <= 1'b1;
              busy      <= 1'b1;
              state_q   <= S_EN_WAIT;
            end
            default: ;
          endcase
        end
        S_EN_WAIT: if (expire) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          state_q <= S_IDLE;
        end
        S_OP_CLR: begin
          core_nres <= 1'b0;
          host_nres <= 1'b0;
          fifo_nres <= 1'b0;
          state_q   <= S_OP_HOLD;
        end
        S_OP_HOLD: if (expire) begin
          core_nres <= 1'b1;
          state_q   <= S_REL_HOST;
        end
        S_REL_HOST: begin
          host_nres <= 1'b1;
          state_q   <= S_REL_FIFO;
        end
        S_REL_FIFO: begin
          fifo_nres <= 1'b1;
          state_q   <= S_IRQ_WR;
        end
        S_IRQ_WR: begin
          irq_sys_en <= 1'b1;
          irq_err_en <= 1'b1;
          state_q    <= S_THR_WR;
        end
        S_THR_WR: begin
          fifo_thresh <= THR_W'(THRESH_VAL);
          busy        <= 1'b0;
          done        <= 1'b1;
          state_q     <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R8: an accepted close drops every reset control at the next edge
  p_close_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    close_acc |=> (!core_nres && !host_nres && !fifo_nres && done));

  // R9: while a sequence runs, a close request does not cut it short
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_REL_HOST && close_req) |=> host_nres);

endmodule

// File: rtl/adapter_bringup_seq.sv
module adapter_bringup_seq #(
  parameter int TICK_DIV   = 1,
  parameter int HOLD_UNITS = 100,
  parameter int THRESH_VAL = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       open_req,
  input  logic       close_req,
  input  logic       enable_req,
  output logic       core_nres,
  output logic       host_nres,
  output logic       fifo_nres,
  output logic       irq_sys_en,
  output logic       irq_err_en,
  output logic [7:0] fifo_thresh,
  output logic       busy,
  output logic       done
);
  localparam int THR_W = 8;

  logic unit_pulse;
  logic hold_expire;
  logic tmr_run;
  logic tmr_clr;
  logic close_acc;

  assign tmr_clr = !tmr_run;

  tick_divider #(.TICK_DIV(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(us_tick),
    .unit_pulse(unit_pulse)
  );

  hold_timer #(.HOLD_UNITS(HOLD_UNITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run),
    .unit_pulse(unit_pulse), .expire(hold_expire)
  );

  bringup_fsm #(.THR_W(THR_W), .THRESH_VAL(THRESH_VAL)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .open_req(open_req), .close_req(close_req), .enable_req(enable_req),
    .expire(hold_expire), .tmr_run(tmr_run), .close_acc(close_acc),
    .core_nres(core_nres), .host_nres(host_nres), .fifo_nres(fifo_nres),
    .irq_sys_en(irq_sys_en), .irq_err_en(irq_err_en),
    .fifo_thresh(fifo_thresh), .busy(busy), .done(done)
  );

  // R5: host interface is released only with the core already out of reset
  p_host_after_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_nres) |-> core_nres);

  // R5: FIFO is released last
  p_fifo_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_nres) |-> (core_nres && host_nres));

  // R5: never two release edges in one cycle
  p_one_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({$rose(core_nres), $rose(host_nres), $rose(fifo_nres)}) <= 1);

  // R6: interrupt pair is set right after the FIFO release
  p_irq_after_fifo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_nres) |=> (irq_sys_en && irq_err_en));

  // R7: threshold changes only once interrupts are on, together with done
  p_thr_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fifo_thresh) |-> (irq_sys_en && irq_err_en && done));

  // R11: busy ends only with done, and they never overlap
  p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R12: a wait never ends on a cycle without a tick
  p_tick_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hold_expire |-> us_tick);

endmodule

// File: tb/tb_adapter_bringup_seq.sv
module tb_adapter_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int HU   = 5;
  localparam int H    = DIV * HU;
  localparam int THR  = 30;

  logic clk = 0, rst_n = 0, us_tick = 1;
  logic open_req = 0, close_req = 0, enable_req = 0;
  logic core_nres, host_nres, fifo_nres, irq_sys_en, irq_err_en, busy, done;
  logic [7:0] fifo_thresh;

  adapter_bringup_seq #(.TICK_DIV(DIV), .HOLD_UNITS(HU), .THRESH_VAL(THR)) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .open_req(open_req),
    .close_req(close_req), .enable_req(enable_req), .core_nres(core_nres),
    .host_nres(host_nres), .fifo_nres(fifo_nres), .irq_sys_en(irq_sys_en),
    .irq_err_en(irq_err_en), .fifo_thresh(fifo_thresh), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          at;
    logic [14:0] w;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0, n_bad = 0;
  bit   finished = 0;

  // model of the last known output values
  logic m_core = 0, m_host = 0, m_fifo = 0;
  logic [1:0] m_irq = 0;
  logic [7:0] m_thr = 0;

  function automatic logic [14:0] pack(logic c, logic h, logic f, logic [1:0] i,
                                       logic [7:0] t, logic b, logic d);
    return {c, h, f, i, t, b, d};
  endfunction

  function automatic logic [14:0] actual();
    return pack(core_nres, host_nres, fifo_nres, {irq_sys_en, irq_err_en},
                fifo_thresh, busy, done);
  endfunction

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  // monitor: compare expected items as their cycle comes up
  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0 && q[0].at <= cyc) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (e.at != cyc || actual() !== e.w) begin
          n_bad++;
          $display("FAIL %s cyc=%0d got=%h exp=%h", e.tag, cyc, actual(), e.w);
        end
      end
    end
  end

  task automatic push(int at, logic [14:0] w, string tag);
    exp_t e;
    e.at = at; e.w = w; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // driver: issue requests, push expectations from the requirements
  task automatic request(bit o, bit cl, bit en, bit noise);
    int c;
    @(negedge clk);
    c = cyc;
    open_req = o; close_req = cl; enable_req = en;
    if (cl) begin // R8 / R10
      push(c + 1, pack(0, 0, 0, m_irq, m_thr, 0, 1), "R8 close");
      push(c + 2, pack(0, 0, 0, m_irq, m_thr, 0, 0), "R8 after");
      m_core = 0; m_host = 0; m_fifo = 0;
    end else if (o) begin
      push(c + 1,     pack(1, m_host, m_fifo, m_irq, m_thr, 1, 0), "R3 core set");
      push(c + 2,     pack(0, 0, 0, m_irq, m_thr, 1, 0), "R3 all clear");
      push(c + 1 + H, pack(0, 0, 0, m_irq, m_thr, 1, 0), "R4 hold end");
      push(c + 2 + H, pack(1, 0, 0, m_irq, m_thr, 1, 0), "R5 core rel");
      push(c + 3 + H, pack(1, 1, 0, m_irq, m_thr, 1, 0), "R5 host rel");
      push(c + 4 + H, pack(1, 1, 1, m_irq, m_thr, 1, 0), "R5 fifo rel");
      push(c + 5 + H, pack(1, 1, 1, 2'b11, m_thr, 1, 0), "R6 irq");
      push(c + 6 + H, pack(1, 1, 1, 2'b11, 8'(THR), 0, 1), "R7 thresh");
      push(c + 7 + H, pack(1, 1, 1, 2'b11, 8'(THR), 0, 0), "R11 done pulse");
      m_core = 1; m_host = 1; m_fifo = 1; m_irq = 2'b11; m_thr = 8'(THR);
    end else if (en) begin
      push(c + 1,     pack(1, m_host, m_fifo, m_irq, m_thr, 1, 0), "R2 core set");
      push(c + H,     pack(1, m_host, m_fifo, m_irq, m_thr, 1, 0), "R2 still busy");
      push(c + 1 + H, pack(1, m_host, m_fifo, m_irq, m_thr, 0, 1), "R2 done");
      m_core = 1;
    end
    @(negedge clk);
    open_req = 0; close_req = 0; enable_req = 0;
    if (noise) begin // R9: requests mid-sequence must change nothing
      repeat (3) @(negedge clk);
      close_req = 1; enable_req = 1; open_req = 1;
      @(negedge clk);
      close_req = 0; enable_req = 0; open_req = 0;
    end
    drain();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        n_cmp++; // R1
        if (actual() !== 15'd0) begin
          n_bad++;
          $display("FAIL R1 in reset got=%h exp=%h", actual(), 15'd0);
        end
        rst_n = 1;
        @(negedge clk);
        n_cmp++; // R1
        if (actual() !== 15'd0) begin
          n_bad++;
          $display("FAIL R1 after reset got=%h exp=%h", actual(), 15'd0);
        end
        request(1, 0, 0, 0);   // plain open
        request(0, 1, 0, 0);   // close
        request(0, 0, 1, 0);   // enable from closed: host/fifo stay low
        request(1, 0, 0, 1);   // open with ignored requests (R9)
        request(0, 0, 1, 0);   // enable with all released
        request(1, 1, 1, 0);   // R10: close wins
        request(1, 0, 1, 0);   // R10: open over enable
        request(0, 1, 0, 0);
        // R12: stalled tick holds the wait
        begin
          int c;
          @(negedge clk);
          c = cyc;
          enable_req = 1; us_tick = 0;
          push(c + 1, pack(1, 0, 0, m_irq, m_thr, 1, 0), "R12 core set");
          push(c + 20, pack(1, 0, 0, m_irq, m_thr, 1, 0), "R12 stalled");
          @(negedge clk);
          enable_req = 0;
          while (cyc < c + 20) @(negedge clk);
          us_tick = 1;
          push(c + 19 + H, pack(1, 0, 0, m_irq, m_thr, 1, 0), "R12 last wait");
          push(c + 20 + H, pack(1, 0, 0, m_irq, m_thr, 0, 1), "R12 done");
          m_core = 1;
          drain();
        end
      end
      begin
        repeat (20000) @(negedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog got=hung exp=finished");
      end
    join_any
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule